// File: doc/BRIEF.md
# ADC Channel Sequencer with Control/Status Register

This block drives an eight-input analog-to-digital converter from a single 8-bit control/status register. Software writes a channel code, a mode bit (one conversion or repeating sweeps), a speed bit and a start bit. The sequencer then steps through the chosen channels. It times each conversion with a down-counter and stores the converter's result for each channel in a result register for that channel. When the conversion or the sweep finishes, a done flag goes high. The flag can raise an interrupt request if the enable bit allows it.

The converter is modelled by a result input port. The block drives the channel number on `conv_chan` and samples `conv_data` on the edge that ends each conversion. The bus is a simple strobe interface. Address 0 selects the control/status register. Addresses 8 to 15 select the result registers for channels 0 to 7. The done flag clears only through a read-then-write sequence, so software cannot clear it by accident.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the control/status register reads 0x00, `irq` is low and all eight result registers read 0.
- R2: With the mode bit (bit 4) at 0, setting start (bit 5) converts exactly the one channel given by the code (bits 2:0). Start then returns to 0 by itself and the done flag (bit 7) goes to 1.
- R3: With the mode bit at 1, code bit 2 picks the base channel (0 or 4) and code bits 1:0 give the top channel's offset from that base. The channels are converted in ascending order from the base up to the code's channel.
- R4: Each conversion takes SLOW_CYC cycles when the speed bit (bit 3) is 0 and FAST_CYC cycles when it is 1. For a single conversion started by a write on clock edge E, the flag reads 0 after edge E+N and reads 1 after edge E+N+1.
- R5: In repeating mode, sweeps follow one another while start stays 1. Writing start to 0 stops the sequencer at once, and the conversion that was cut short stores no result.
- R6: Writing 1 to the done flag does not set it.
- R7: Writing 0 to the done flag clears it only if a bus read of address 0 returned the flag as 1 since the flag was set. A 0 written without that read leaves the flag at 1.
- R8: If a sweep ends on the same edge as a clearing write, the flag stays at 1.
- R9: `irq` is high exactly while the done flag and the interrupt enable (bit 6) are both 1.
- R10: Changes to the code, mode or speed bits made while a sweep is running take effect only at the start of the next sweep.
- R11: Result register ch (address 8+ch) holds the `conv_data` value sampled on the edge that ends that channel's conversion, and it changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | RES_W | Read data (combinational on bus_addr) |
| conv_data | input | RES_W | Converter result for the channel on conv_chan |
| conv_chan | output | 3 | Channel currently being converted |
| irq | output | 1 | Interrupt request |

## Verification
Embedded assertions check on every cycle that:
- the flag falls only after an armed clearing write;
- the flag rises only on a sweep end, and a sweep end always leaves it set;
- the channel stays inside the latched range and the timer stays within its bound;
- the latched configuration holds steady during a sweep, and a halt stops the sequencer;
- a result register changes only when its own channel finishes.

Only the bench's scenarios can show the rest:
- the exact conversion latency;
- which channels each of the sixteen mode and code settings visits;
- that back-to-back sweeps repeat;
- that a change of configuration in mid-sweep waits for the next sweep;
- that a clearing write timed onto a sweep end loses.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int NCH  = 8;
  localparam int CH_W = 3;

  typedef struct packed {
    logic            flag;
    logic            ie;
    logic            start;
    logic            scan;
    logic            speed;
    logic [CH_W-1:0] code;
  } ctrl_t;

  // lowest channel of a sweep
  function automatic logic [CH_W-1:0] sweep_first(input logic scan, input logic [CH_W-1:0] code);
    return scan ? {code[CH_W-1], {(CH_W-1){1'b0}}} : code;
  endfunction

  // highest channel of a sweep (the code itself in both modes)
  function automatic logic [CH_W-1:0] sweep_last(input logic [CH_W-1:0] code);
    return code;
  endfunction

  // cycles per conversion
  function automatic int unsigned conv_len(input logic speed, input int unsigned slow_c,
                                           input int unsigned fast_c);
    return speed ? fast_c : slow_c;
  endfunction

endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  input  logic        sweep_end,
  input  logic        single_end,
  output ctrl_t       ctrl_q,
  output logic        irq
);

  logic  armed_q;
  logic  clr_req;
  ctrl_t wr_view;

  assign wr_view = ctrl_t'(wdata);
  assign clr_req = wr_en && !wr_view.flag && armed_q && ctrl_q.flag;
  assign irq     = ctrl_q.flag && ctrl_q.ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_en) begin
        ctrl_q.ie    <= wr_view.ie;
        ctrl_q.start <= wr_view.start;
        ctrl_q.scan  <= wr_view.scan;
        ctrl_q.speed <= wr_view.speed;
        ctrl_q.code  <= wr_view.code;
      end else if (single_end) begin
        ctrl_q.start <= 1'b0;
      end
      if (sweep_end)    ctrl_q.flag <= 1'b1;
      else if (clr_req) ctrl_q.flag <= 1'b0;
      if (clr_req)                     armed_q <= 1'b0;
      else if (rd_en && ctrl_q.flag)   armed_q <= 1'b1;
    end
  end

  // R7
  flag_clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.flag) |-> $past(armed_q && wr_en && !wdata[7]));
  // R6
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.flag) |-> $past(sweep_end));
  // R8
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_end |=> ctrl_q.flag);
  // R2
  start_autoclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_end && !wr_en) |=> !ctrl_q.start);

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int unsigned SLOW_CYC = 242,
  parameter int unsigned FAST_CYC = 122
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            scan,
  input  logic            speed,
  input  logic [CH_W-1:0] code,
  output logic [CH_W-1:0] chan,
  output logic            conv_done,
  output logic            sweep_end,
  output logic            single_end
);

  localparam int CNT_W = $clog2(SLOW_CYC + 1);

  logic             busy_q;
  logic [CH_W-1:0]  ch_q, first_l, last_l;
  logic [CNT_W-1:0] cnt_q;
  logic             scan_l, speed_l;

  assign chan       = ch_q;
  assign conv_done  = busy_q && start && (cnt_q == '0);
  assign sweep_end  = conv_done && (ch_q == last_l);
  assign single_end = sweep_end && !scan_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ch_q    <= '0;
      first_l <= '0;
      last_l  <= '0;
      cnt_q   <= '0;
      scan_l  <= 1'b0;
      speed_l <= 1'b0;
    end else if ((!busy_q && start) || (sweep_end && scan_l)) begin
      busy_q  <= 1'b1;
      ch_q    <= sweep_first(scan, code);
      first_l <= sweep_first(scan, code);
      last_l  <= sweep_last(code);
      scan_l  <= scan;
      speed_l <= speed;
      cnt_q   <= CNT_W'(conv_len(speed, SLOW_CYC, FAST_CYC) - 1);
    end else if (busy_q) begin
      if (!start || single_end) begin
        busy_q <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        ch_q  <= ch_q + 1'b1;
        cnt_q <= CNT_W'(conv_len(speed_l, SLOW_CYC, FAST_CYC) - 1);
      end
    end
  end

  // R3
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ch_q >= first_l && ch_q <= last_l));
  // R4
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (32'(cnt_q) < conv_len(speed_l, SLOW_CYC, FAST_CYC)));
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(sweep_end)) |->
      ($stable(last_l) && $stable(scan_l) && $stable(speed_l)));
  // R5
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |=> !busy_q);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CH_W-1:0]  widx,
  input  logic [RES_W-1:0] wdata,
  input  logic [CH_W-1:0]  ridx,
  output logic [RES_W-1:0] rdata
);

  logic [RES_W-1:0] regs [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                            regs[i] <= '0;
      else if (we && widx == CH_W'(i))       regs[i] <= wdata;
    end
    // R11
    res_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs[i]) |-> $past(we && widx == CH_W'(i)));
  end

  assign rdata = regs[ridx];

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int          RES_W    = 10,
  parameter int unsigned SLOW_CYC = 242,
  parameter int unsigned FAST_CYC = 122
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [3:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [RES_W-1:0] bus_rdata,
  input  logic [RES_W-1:0] conv_data,
  output logic [CH_W-1:0]  conv_chan,
  output logic             irq
);

  ctrl_t            ctrl_q;
  logic             sel_ctrl, sel_res;
  logic             conv_done, sweep_end, single_end;
  logic [RES_W-1:0] res_rdata;

  assign sel_ctrl = (bus_addr == 4'd0);
  assign sel_res  = bus_addr[3];

  adc_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr && sel_ctrl),
    .rd_en      (bus_rd && sel_ctrl),
    .wdata      (bus_wdata),
    .sweep_end  (sweep_end),
    .single_end (single_end),
    .ctrl_q     (ctrl_q),
    .irq        (irq)
  );

  adc_sequencer #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ctrl_q.start),
    .scan       (ctrl_q.scan),
    .speed      (ctrl_q.speed),
    .code       (ctrl_q.code),
    .chan       (conv_chan),
    .conv_done  (conv_done),
    .sweep_end  (sweep_end),
    .single_end (single_end)
  );

  adc_result_bank #(.RES_W(RES_W)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (conv_done),
    .widx  (conv_chan),
    .wdata (conv_data),
    .ridx  (bus_addr[CH_W-1:0]),
    .rdata (res_rdata)
  );

  always_comb begin
    if (sel_ctrl)     bus_rdata = RES_W'(ctrl_q);
    else if (sel_res) bus_rdata = res_rdata;
    else              bus_rdata = '0;
  end

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.flag || !ctrl_q.ie) |-> !irq);

endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb_top;

  localparam int RES_W = 10;
  localparam int SLOW  = 242;
  localparam int FAST  = 122;

  logic             clk = 0, rst_n = 0;
  logic             bus_wr = 0, bus_rd = 0;
  logic [3:0]       bus_addr = 0;
  logic [7:0]       bus_wdata = 0;
  logic [RES_W-1:0] bus_rdata, conv_data;
  logic [2:0]       conv_chan;
  logic             irq;
  int               salt = 0;
  int               cyc = 0;
  int               checks = 0, errors = 0;
  bit               done = 0;
  logic [RES_W-1:0] exp_res [8];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [RES_W-1:0] model(input int ch, input int s);
    return RES_W'((ch * 97 + s * 13 + 3) % 1024);
  endfunction

  assign conv_data = model(int'(conv_chan), salt);

  adc_seq_top #(.RES_W(RES_W), .SLOW_CYC(SLOW), .FAST_CYC(FAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_data(conv_data),
    .conv_chan(conv_chan), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write on the next edge; returns at the negedge after it
  task automatic wr_now(input logic [7:0] d);
    bus_wr = 1; bus_addr = 0; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk);
    wr_now(d);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [RES_W-1:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 0; bus_addr = 0;
  endtask

  task automatic peek(output logic [7:0] v);
    bus_addr = 0;
    #1 v = bus_rdata[7:0];
  endtask

  task automatic wait_flag();
    logic [7:0] v;
    for (int i = 0; i < 4 * SLOW * 8; i++) begin
      @(negedge clk);
      peek(v);
      if (v[7]) break;
    end
  endtask

  task automatic clear_flag();
    logic [RES_W-1:0] v;
    bus_read(0, v);
    bus_write(8'h00);
  endtask

  task automatic check_results(input string req);
    logic [RES_W-1:0] v;
    for (int ch = 0; ch < 8; ch++) begin
      bus_read(4'(8 + ch), v);
      chk(req, int'(v), int'(exp_res[ch]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]       c;
    logic [RES_W-1:0] v;
    int               e, t2;
    for (int i = 0; i < 8; i++) exp_res[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    peek(c);
    chk("R1 ctrl", c, 0);
    chk("R1 irq", irq, 0);
    check_results("R1 results");

    // R6 writing 1 to flag is ignored
    bus_write(8'h80);
    peek(c);
    chk("R6 flag not settable", c[7], 0);

    // R4 slow latency, single on channel 5
    salt = 1;
    bus_write(8'h25);
    repeat (SLOW) @(negedge clk);
    peek(c);
    chk("R4 slow flag before end", c[7], 0);
    @(negedge clk);
    peek(c);
    chk("R4 slow flag at end", c[7], 1);
    chk("R2 start autoclear", c[5], 0);
    chk("R9 irq masked", irq, 0);
    exp_res[5] = model(5, 1);
    bus_read(4'd13, v);
    chk("R11 result ch5", int'(v), int'(exp_res[5]));

    // R7 write 0 without read keeps flag
    bus_write(8'h00);
    peek(c);
    chk("R7 no prior read", c[7], 1);
    // R9 enable raises irq; R6 writing 1 leaves flag as is
    bus_write(8'hC0);
    @(negedge clk);
    chk("R9 irq on", irq, 1);
    bus_read(0, v);
    chk("R7 read sees flag", int'(v[7]), 1);
    bus_write(8'h40);
    peek(c);
    chk("R7 clear after read", c[7], 0);
    chk("R9 irq off", irq, 0);
    bus_write(8'h00);

    // R4 fast latency, single on channel 2
    salt = 2;
    bus_write(8'h2A);
    repeat (FAST) @(negedge clk);
    peek(c);
    chk("R4 fast flag before end", c[7], 0);
    @(negedge clk);
    peek(c);
    chk("R4 fast flag at end", c[7], 1);
    exp_res[2] = model(2, 2);
    clear_flag();

    // R2 all single codes
    for (int code = 0; code < 8; code++) begin
      salt = 10 + code;
      bus_write(8'(8'h28 | code));
      wait_flag();
      peek(c);
      chk("R2 single start clear", c[5], 0);
      exp_res[code] = model(code, salt);
      check_results("R2 single channel");
      clear_flag();
    end

    // R3 all scan codes, R5 halt aborts restarted sweep
    for (int code = 0; code < 8; code++) begin
      salt = 30 + code;
      bus_write(8'(8'h38 | code));
      wait_flag();
      wr_now(8'(8'h08 | code));
      for (int ch = (code & 4); ch <= code; ch++) exp_res[ch] = model(ch, salt);
      salt = 60;
      repeat (2 * FAST) @(negedge clk);
      check_results("R3 scan group");
      peek(c);
      chk("R5 halted start", c[5], 0);
      clear_flag();
    end

    // R5 cyclic sweeps on AN0..AN1
    salt = 70;
    bus_write(8'h39);
    wait_flag();
    bus_read(0, v);
    bus_write(8'h39);
    peek(c);
    chk("R5 cleared while running", c[7], 0);
    salt = 71;
    wait_flag();
    wr_now(8'h09);
    exp_res[0] = model(0, 71);
    exp_res[1] = model(1, 71);
    check_results("R5 second sweep");
    clear_flag();

    // R10 mid-sweep code change deferred
    salt = 80;
    bus_write(8'h3B);
    repeat (10) @(negedge clk);
    bus_write(8'h38);
    wait_flag();
    wr_now(8'h08);
    for (int ch = 0; ch < 4; ch++) exp_res[ch] = model(ch, 80);
    check_results("R10 deferred config");
    clear_flag();

    // R8 set beats clear on the same edge
    salt = 90;
    @(negedge clk);
    e = cyc + 1;
    wr_now(8'h38);
    t2 = e + 2 * FAST + 1;
    wait_flag();
    bus_read(0, v);
    while (cyc != t2 - 1) @(negedge clk);
    wr_now(8'h38);
    peek(c);
    chk("R8 set wins", c[7], 1);
    wr_now(8'h08);
    exp_res[0] = model(0, 90);
    clear_flag();
    peek(c);
    chk("R8 later clear", c[7], 0);
    check_results("R11 final results");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule